// File: doc/BRIEF.md
# Token-Ordered Link Readout Sequencer

This block drains event blocks from up to sixteen input buffers onto one shared 39-bit link word. A single token marks the channel that may send. The token starts each event on channel 0. It moves upward through the channels that are not masked out, and it returns to channel 0 once the highest enabled channel has delivered the word that closes its block. Each input buffer is seen as a ready/valid source that also supplies a block-end flag and a control flag with every 32-bit data word.

Each outgoing word carries a routing field of destination bits. The field is set per input at configuration time and does not change from word to word. The downstream side can assert a hold line. While hold is set, the word on the link stays put and no further word is taken from any source, so nothing is dropped. A global enable parks the token on channel 0 and stops all reading while it is low.

Top module: `link_token_seq`

## Requirements
- R1: Within an event, channels are read in ascending index order. The token leaves a channel only in the cycle in which that channel's word with the block-end flag is taken. At most one source sees ready in any cycle.
- R2: A channel whose `skip_mask` bit is set (channels 1 and up) never sees ready, and none of its words reaches the link. Bit 0 of `skip_mask` has no effect: channel 0 is always read.
- R3: After reset, or after an event has finished, the token sits on channel 0. No other channel is read until channel 0 has delivered its block, however long channel 0 stays empty.
- R4: When the block-end word of the highest non-skipped channel is taken, the token returns to channel 0 and `src_ready` becomes 16'h0001 while the link stage is empty.
- R5: The link word layout is: bits [31:0] data, bit 32 control flag, bit 33 word-valid, bit 34 block-end, bits [38:35] destination field.
- R6: The destination field of every word equals `dir_cfg[4*c+3:4*c]` of the channel c it came from.
- R7: While `hold` is high and bit 33 of `link_word` is set, `link_word` keeps its value on the next cycle and `src_ready` is all zero.
- R8: While `tok_en` is low, `src_ready` is all zero, no new word enters the link, and the token is forced to channel 0.
- R9: Under reset, `link_word` is all zero.
- R10: Each word taken from a source appears exactly once on the link, in the order taken. A word counts as consumed in a cycle where bit 33 is set and `hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_en | input | 1 | Token enable; low parks the token at channel 0 |
| hold | input | 1 | Downstream busy; freezes a valid link word |
| skip_mask | input | 16 | Per-channel skip configuration (bit 0 ignored) |
| dir_cfg | input | 64 | Four destination bits per channel, channel c at [4c+3:4c] |
| src_valid | input | 16 | Source word available, one bit per channel |
| src_ready | output | 16 | Source word taken this cycle when valid |
| src_data | input | 512 | 32-bit data per channel, channel c at [32c+31:32c] |
| src_cbit | input | 16 | Control flag per channel |
| src_last | input | 16 | Block-end flag per channel |
| link_word | output | 39 | Registered outgoing link word |

## Verification
The two functions that can meet in one cycle are the token advance and the downstream hold. A block-end word may be taken in the same cycle in which hold rises, and hold may fall while the token is moving to a new channel. Random hold and random source gaps are applied throughout multi-event runs to provoke these overlaps. Every consumed link word is compared in order against a queue computed from the skip mask and the per-channel block lengths. Each held cycle is checked for a frozen word with no source ready.

// File: rtl/lts_pkg.sv
package lts_pkg;

    // Field widths of the outgoing link word.
    localparam int LK_DATA_W = 32;
    localparam int LK_DIR_W  = 4;
    localparam int LK_W      = LK_DATA_W + LK_DIR_W + 3;

    // Packed link word; the bit layout is relied on by the downstream side.
    typedef struct packed {
        logic [LK_DIR_W-1:0]  dir;
        logic                 last;
        logic                 vld;
        logic                 cbit;
        logic [LK_DATA_W-1:0] data;
    } link_word_t;

endpackage

// File: rtl/lts_next_pick.sv
// lts_next_pick
// Finds the lowest non-skipped channel above the current token position.
// When none exists, it points back at channel 0 and flags the wrap.
// Assumes: purely combinational; bit 0 of the skip mask is never consulted.
module lts_next_pick #(
    parameter int NUM_CH = 16,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [IDX_W-1:0]  cur,
    input  logic [NUM_CH-1:0] skip,
    output logic [IDX_W-1:0]  nxt,
    output logic              wrap
);

    // Downward scan so that the lowest qualifying index wins.
    always_comb begin
        nxt  = '0;
        wrap = 1'b1;
        for (int j = NUM_CH - 1; j >= 1; j--) begin
            if ((j > int'(cur)) && !skip[j]) begin
                nxt  = IDX_W'(j);
                wrap = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lts_token_ctrl.sv
// lts_token_ctrl
// Holds the token position. It advances when a block-end word is taken and
// is forced back to channel 0 when the global enable is low.
// Assumes: nxt was computed from the current token and the skip mask.
module lts_token_ctrl #(
    parameter int NUM_CH = 16,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_en,
    input  logic             pop,
    input  logic             pop_last,
    input  logic [IDX_W-1:0] nxt,
    output logic [IDX_W-1:0] tok
);

    // Token register: park, advance on block end, or stay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok <= '0;
        end else if (!tok_en) begin
            tok <= '0;
        end else if (pop && pop_last) begin
            tok <= nxt;
        end
    end

    AST_TOKEN_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_en |=> (tok == '0)); // R8

    AST_TOKEN_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_en && pop && pop_last) |=> ((tok == '0) || (tok > $past(tok)))); // R1

    AST_TOKEN_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_en && !(pop && pop_last)) |=> $stable(tok)); // R1

endmodule

// File: rtl/lts_src_mux.sv
// lts_src_mux
// Decodes the token into per-channel ready signals. It selects the granted
// channel's word and stamps it with that channel's destination field.
// Assumes: grant already folds in the enable and the output-stage space.
module lts_src_mux #(
    parameter int NUM_CH = 16,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int DW    = lts_pkg::LK_DATA_W,
    localparam int DIRW  = lts_pkg::LK_DIR_W
) (
    input  logic [IDX_W-1:0]       tok,
    input  logic                   grant,
    input  logic [NUM_CH-1:0]      src_valid,
    input  logic [NUM_CH*DW-1:0]   src_data,
    input  logic [NUM_CH-1:0]      src_cbit,
    input  logic [NUM_CH-1:0]      src_last,
    input  logic [NUM_CH*DIRW-1:0] dir_cfg,
    output logic [NUM_CH-1:0]      src_ready,
    output lts_pkg::link_word_t    sel_word,
    output logic                   pop
);

    // One ready line per channel, high only at the token position.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rdy
        assign src_ready[ch] = grant && (tok == IDX_W'(ch));
    end

    // Assemble the candidate link word from the token channel.
    always_comb begin
        sel_word.data = src_data[tok*DW +: DW];
        sel_word.cbit = src_cbit[tok];
        sel_word.vld  = 1'b1;
        sel_word.last = src_last[tok];
        sel_word.dir  = dir_cfg[tok*DIRW +: DIRW];
    end

    // A word leaves its source when granted and present.
    assign pop = grant && src_valid[tok];

endmodule

// File: rtl/lts_out_stage.sv
// lts_out_stage
// Single link output register. A valid word is frozen while hold is high,
// and a new word may load only when the register is empty or is draining.
// Assumes: take is only raised while load_ok is high.
module lts_out_stage (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic                take,
    input  lts_pkg::link_word_t in_word,
    output logic                load_ok,
    output lts_pkg::link_word_t out_word
);

    // Space exists when nothing is held on the link.
    assign load_ok = !out_word.vld || !hold;

    // Output register: load a taken word, or clear when it drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
        end else if (load_ok) begin
            out_word <= take ? in_word : '0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_word.vld && hold) |=> $stable(out_word)); // R7

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> load_ok); // R10

endmodule

// File: rtl/link_token_seq.sv
// link_token_seq
// Token-ordered readout of NUM_CH ready/valid sources onto one link word.
// Channel 0 opens every event. Masked channels above 0 are passed over. Each
// word carries its channel's configured destination bits. Downstream hold
// freezes the registered link word.
// Assumes: skip_mask and dir_cfg are static while traffic flows.
module link_token_seq #(
    parameter int NUM_CH = 16,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int DW    = lts_pkg::LK_DATA_W,
    localparam int DIRW  = lts_pkg::LK_DIR_W,
    localparam int LW    = lts_pkg::LK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tok_en,
    input  logic                   hold,
    input  logic [NUM_CH-1:0]      skip_mask,
    input  logic [NUM_CH*DIRW-1:0] dir_cfg,
    input  logic [NUM_CH-1:0]      src_valid,
    output logic [NUM_CH-1:0]      src_ready,
    input  logic [NUM_CH*DW-1:0]   src_data,
    input  logic [NUM_CH-1:0]      src_cbit,
    input  logic [NUM_CH-1:0]      src_last,
    output logic [LW-1:0]          link_word
);

    logic [IDX_W-1:0]    tok;
    logic [IDX_W-1:0]    nxt;
    logic                wrap;
    logic                load_ok;
    logic                grant;
    logic                pop;
    lts_pkg::link_word_t sel_word;
    lts_pkg::link_word_t out_word;

    // Sources may be served only when enabled and the link stage has room.
    assign grant = tok_en && load_ok;

    lts_next_pick #(.NUM_CH(NUM_CH)) u_pick (
        .cur  (tok),
        .skip (skip_mask),
        .nxt  (nxt),
        .wrap (wrap)
    );

    lts_token_ctrl #(.NUM_CH(NUM_CH)) u_tok (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_en   (tok_en),
        .pop      (pop),
        .pop_last (sel_word.last),
        .nxt      (nxt),
        .tok      (tok)
    );

    lts_src_mux #(.NUM_CH(NUM_CH)) u_mux (
        .tok       (tok),
        .grant     (grant),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_cbit  (src_cbit),
        .src_last  (src_last),
        .dir_cfg   (dir_cfg),
        .src_ready (src_ready),
        .sel_word  (sel_word),
        .pop       (pop)
    );

    lts_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .take     (pop),
        .in_word  (sel_word),
        .load_ok  (load_ok),
        .out_word (out_word)
    );

    assign link_word = out_word;

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready)); // R1

    AST_SKIP_NEVER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_ready & skip_mask) >> 1) == '0); // R2

    AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_word.vld && hold) |-> (src_ready == '0)); // R7

    AST_RETURN_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_en && pop && sel_word.last && wrap) |=> (tok == '0)); // R4

    AST_DISABLED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_en |=> !out_word.vld || $stable(out_word) || !$past(out_word.vld)); // R8

endmodule

// File: tb/link_token_seq_bench.sv
module link_token_seq_bench;

    localparam int CLK_PERIOD = 25;
    localparam int NCH   = 16;
    localparam int DEPTH = 256;
    localparam int WDOG  = 100000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tok_en;
    logic              hold;
    logic [NCH-1:0]    skip_mask;
    logic [NCH*4-1:0]  dir_cfg;
    logic [NCH-1:0]    src_valid;
    logic [NCH-1:0]    src_ready;
    logic [NCH*32-1:0] src_data;
    logic [NCH-1:0]    src_cbit;
    logic [NCH-1:0]    src_last;
    logic [38:0]       link_word;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_token_seq u_link_token_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_en    (tok_en),
        .hold      (hold),
        .skip_mask (skip_mask),
        .dir_cfg   (dir_cfg),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .src_data  (src_data),
        .src_cbit  (src_cbit),
        .src_last  (src_last),
        .link_word (link_word)
    );

    // Per-channel source memories: {last, cbit, data}.
    logic [33:0] chm [NCH][DEPTH];
    int          wr [NCH];
    int          rd [NCH];
    logic [NCH-1:0] gate;
    logic        block0;
    logic        rnd;
    logic [38:0] exp_q [$];
    logic [38:0] prev_word;
    logic        held_prev;
    int          checks;
    int          failures;
    int          cyc;
    logic        wdog_hit;

    // Record one check, printing a FAIL line on mismatch.
    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present the head of each source memory.
    task automatic drive_src();
        for (int c = 0; c < NCH; c++) begin
            src_valid[c] = (rd[c] < wr[c]) && gate[c] && !(c == 0 && block0);
            src_data[c*32 +: 32] = chm[c][rd[c]][31:0];
            src_cbit[c] = chm[c][rd[c]][32];
            src_last[c] = chm[c][rd[c]][33];
        end
    endtask

    // Expected link word for a source entry of channel c.
    function automatic logic [38:0] exp_word(input int c, input logic [33:0] e);
        return {dir_cfg[c*4 +: 4], e[33], 1'b1, e[32], e[31:0]};
    endfunction

    // Build one event: blocks for channel 0 and every non-skipped channel.
    task automatic gen_event();
        for (int c = 0; c < NCH; c++) begin
            if (c == 0 || !skip_mask[c]) begin
                int n;
                n = 1 + int'($urandom % 3);
                for (int k = 0; k < n; k++) begin
                    logic [33:0] e;
                    e = {(k == n - 1), 1'($urandom), 32'($urandom)};
                    chm[c][wr[c]] = e;
                    wr[c]++;
                    exp_q.push_back(exp_word(c, e));
                end
            end
        end
        drive_src();
    endtask

    // One clock cycle: observe at negedge, update sources after posedge.
    task automatic step();
        logic [NCH-1:0] fire;
        @(negedge clk);
        cyc++;
        if (cyc > WDOG && !wdog_hit) begin
            wdog_hit = 1'b1;
            chk(1'b0, "watchdog", 64'(cyc), 64'(WDOG));
        end
        if (rst_n) begin
            if (link_word[33]) begin
                if (held_prev)
                    chk(link_word == prev_word, "R7 held word stable", 64'(link_word), 64'(prev_word));
                if (hold)
                    chk(src_ready == '0, "R7 no ready under hold", 64'(src_ready), 64'h0);
                if (!hold) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected word", 64'(link_word), 64'h0);
                    end else begin
                        logic [38:0] e;
                        e = exp_q.pop_front();
                        chk(link_word == e, "R1 R5 R6 R10 word order/layout", 64'(link_word), 64'(e));
                    end
                end
            end
            if (((src_ready & skip_mask) >> 1) != '0)
                chk(1'b0, "R2 skipped channel ready", 64'(src_ready), 64'h0);
        end
        held_prev = link_word[33] && hold;
        prev_word = link_word;
        fire = src_valid & src_ready;
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++)
            if (fire[c]) rd[c]++;
        if (rnd) begin
            hold = ($urandom % 10) < 3;
            for (int c = 0; c < NCH; c++) gate[c] = ($urandom % 4) != 0;
        end
        drive_src();
    endtask

    // Run until every expected word has been consumed and the link is idle.
    task automatic drain();
        while ((exp_q.size() != 0 || link_word[33]) && !wdog_hit) step();
    endtask

    initial begin
        void'($urandom(32'd4711));
        checks = 0; failures = 0; cyc = 0; wdog_hit = 1'b0;
        held_prev = 1'b0; prev_word = '0;
        rst_n = 1'b0; tok_en = 1'b1; hold = 1'b0; rnd = 1'b0; block0 = 1'b0;
        skip_mask = 16'b1000_0001_1000_1001;
        for (int c = 0; c < NCH; c++) begin
            dir_cfg[c*4 +: 4] = 4'($urandom);
            wr[c] = 0; rd[c] = 0;
            for (int k = 0; k < DEPTH; k++) chm[c][k] = '0;
        end
        gate = '1;
        // Junk words on skipped channels must never be read (R2).
        for (int c = 1; c < NCH; c++)
            if (skip_mask[c]) begin
                chm[c][0] = {1'b1, 1'b0, 32'hDEAD0000 | 32'(c)};
                wr[c] = 1;
            end
        drive_src();

        repeat (3) step();
        @(negedge clk);
        chk(link_word == '0, "R9 reset link word", 64'(link_word), 64'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_ready == 16'h0001, "R3 token starts at channel 0", 64'(src_ready), 64'h1);

        // R3: later channels hold data while channel 0 stays empty.
        block0 = 1'b1;
        gen_event();
        for (int i = 0; i < 12; i++) begin
            step();
            chk(link_word[33] == 1'b0, "R3 no word before channel 0", 64'(link_word), 64'h0);
            chk((src_ready >> 1) == '0, "R3 only channel 0 ready", 64'(src_ready), 64'h1);
        end
        block0 = 1'b0;
        drive_src();
        drain();
        step();
        chk(src_ready == 16'h0001, "R4 token back at channel 0", 64'(src_ready), 64'h1);

        // R7: long hold with a word on the link.
        gen_event();
        while (!link_word[33]) step();
        hold = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            chk(link_word[33] == 1'b1, "R7 word kept under hold", 64'(link_word), 64'h1);
        end
        hold = 1'b0;
        drain();

        // R8: disabled token takes nothing.
        tok_en = 1'b0;
        gen_event();
        for (int i = 0; i < 10; i++) begin
            step();
            chk(src_ready == '0, "R8 no ready while disabled", 64'(src_ready), 64'h0);
            chk(link_word[33] == 1'b0, "R8 no word while disabled", 64'(link_word), 64'h0);
        end
        tok_en = 1'b1;
        drain();

        // Random phase: many events with random hold and source gaps.
        rnd = 1'b1;
        for (int ev = 0; ev < 25; ev++) gen_event();
        drain();
        rnd = 1'b0; hold = 1'b0; gate = '1;
        drive_src();
        step(); step();
        chk(src_ready == 16'h0001, "R4 token home after random run", 64'(src_ready), 64'h1);
        chk(exp_q.size() == 0, "R10 all words delivered", 64'(exp_q.size()), 64'h0);
        for (int c = 1; c < NCH; c++)
            if (skip_mask[c])
                chk(rd[c] == 0, "R2 skipped channel untouched", 64'(rd[c]), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule